// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers eight event sources from the digital core of an audio converter into one read-only status byte. Each status bit latches its event and holds it until software reads the status byte. A mask byte keeps individual sources off the single active-high interrupt line. The eight sources are four per-channel auto-mute events, two serial-port clock-error flags and the two ADC overflow flags.

The auto-mute events come from inside the block. Each of four sample channels has a run-length detector. It watches for a run of consecutive samples that are all zeros or all ones, and flags the channel as muted when the run reaches a programmed length. A mode byte holds one 2-bit trigger field for each source group. The field selects whether a group's status bits latch on the rising edge of the source, on its falling edge, or while the source is high. A separate overflow output always mirrors the live ADC overflow state, whatever the mask says.

Software reaches the block through a simple register port with four addresses, a read strobe and a write strobe. Read data is combinational. A read of the status address clears the status byte at the clock edge that ends the read.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status, mask and mode bytes read 00h and `irq` is low.
- R2: The status byte is read-only. A write to address 0 leaves it unchanged.
- R3: Status bit positions: 7 = channel 3 auto-mute (second DAC, left), 6 = channel 2 (second DAC, right), 5 = channel 1 (first DAC, left), 4 = channel 0 (first DAC, right), 3 = `clk_err[1]`, 2 = `clk_err[0]`, 1 = `adc_ovfl_pos`, 0 = `adc_ovfl_neg`. Level sources are sampled at each clock edge, and a status bit sets at the edge after its trigger is seen.
- R4: A set status bit stays set until the status byte is read.
- R5: A read of address 0 returns the status byte as it stood before the read and clears it at the edge that ends the read. A bit whose trigger occurs in that same cycle stays set.
- R6: A channel becomes muted when its RUN_LEN-th consecutive valid all-zero sample, or all-one sample, is accepted. Cycles with `mute_valid` low neither extend nor break the run.
- R7: A run restarts when a sample is not constant, or when a constant sample has the other polarity from the run. The internal mute pulse lasts one cycle. A muted channel that keeps receiving samples of the same polarity produces no new event.
- R8: When a mask bit is 1, that source cannot raise `irq`, but its status bit still latches.
- R9: `irq` is a registered signal. It equals the OR of (status AND NOT mask) as it stood one cycle earlier.
- R10: `ovfl_out` equals `adc_ovfl_pos` OR `adc_ovfl_neg` at all times, whatever the mask.
- R11: Trigger encoding of each 2-bit mode field: 00 = rising edge of the source level, 01 = falling edge, 10 = level, 11 = level. For the auto-mute group the source level is the channel's muted state.
- R12: Register map: address 0 = status (read-only), 1 = mask (read/write, same bit positions as the status byte), 2 = mode (read/write, bits 5:4 auto-mute group, bits 3:2 clock-error group, bits 1:0 overflow group, bits 7:6 stored but unused), 3 = reads 00h and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_valid | input | 4 | Sample strobe for each auto-mute channel |
| mute_data | input | 4*SAMPLE_W | Samples; channel c occupies bits c*SAMPLE_W upward |
| clk_err | input | 2 | Serial-port clock-error levels (bit 1 port 2, bit 0 port 1) |
| adc_ovfl_pos | input | 1 | ADC positive overflow level |
| adc_ovfl_neg | input | 1 | ADC negative overflow level |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of address 0 clears the status byte) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Registered active-high interrupt |
| ovfl_out | output | 1 | Live ADC overflow indication |

## Verification
The bench builds the block with SAMPLE_W = 8 and RUN_LEN = 6. With these values a full mute run takes a handful of samples, so one run can complete on every channel. The same settings let the bench walk the run restart cases, a break by a non-constant sample and a polarity switch, each stopping one sample short of the limit. A narrow sample also makes the all-ones pattern cheap to drive. Every trigger mode is then exercised on the overflow group, including a trigger that falls in the same cycle as a clearing read.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int NUM_SRC     = 8;
  localparam int NUM_MUTE_CH = 4;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_RSVD  = 2'b11
  } trig_mode_e;

  // Trigger decision for one source given its level now and last cycle.
  function automatic logic trig_hit(input logic [1:0] mode, input logic lvl,
                                    input logic prev);
    case (trig_mode_e'(mode))
      TRIG_RISE: return lvl & ~prev;
      TRIG_FALL: return ~lvl & prev;
      default:   return lvl;
    endcase
  endfunction

  // Picks the 2-bit trigger field that governs status bit idx.
  function automatic logic [1:0] mode_for_bit(input logic [7:0] mode_reg,
                                              input int idx);
    if (idx >= 4)      return mode_reg[5:4];
    else if (idx >= 2) return mode_reg[3:2];
    else               return mode_reg[1:0];
  endfunction

  // Constant-sample classification used by the run detectors.
  function automatic logic [1:0] classify(input logic all_zero,
                                          input logic all_one);
    return {all_zero | all_one, all_one};
  endfunction

endpackage

// File: rtl/run_detector.sv
module run_detector #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] data,
  output logic                muted,
  output logic                mute_pulse
);
  import irq_stat_pkg::*;

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kind_q, kind_d;
  logic             pulse_q;
  logic [1:0]       cls;
  logic             is_const, is_ones, same_run, at_limit;

  assign cls      = classify(data == '0, &data);
  assign is_const = cls[1];
  assign is_ones  = cls[0];
  assign at_limit = (cnt_q == LIMIT);
  assign same_run = (cnt_q != '0) && (kind_q == is_ones);

  always_comb begin
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (valid) begin
      if (!is_const) begin
        cnt_d = '0;
      end else if (!same_run) begin
        cnt_d  = CNT_W'(1);
        kind_d = is_ones;
      end else if (!at_limit) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      kind_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      pulse_q <= valid && (cnt_d == LIMIT) && !(same_run && at_limit);
    end
  end

  assign muted      = at_limit;
  assign mute_pulse = pulse_q;

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mute_pulse |=> !mute_pulse);

  p_pulse_muted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mute_pulse |-> muted);

endmodule

// File: rtl/src_capture.sv
module src_capture #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [7:0]      mode_reg,
  input  logic            clr,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] set_vec
);
  import irq_stat_pkg::*;

  logic [NSRC-1:0] prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_trig
    assign set_vec[i] = trig_hit(mode_for_bit(mode_reg, i), lvl[i], prev_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl;
      status_q <= (clr ? '0 : status_q) | set_vec;
    end
  end

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec == '0) |=> (status_q == '0));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            mute_valid,
  input  logic [4*SAMPLE_W-1:0] mute_data,
  input  logic [1:0]            clk_err,
  input  logic                  adc_ovfl_pos,
  input  logic                  adc_ovfl_neg,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  output logic                  irq,
  output logic                  ovfl_out
);
  import irq_stat_pkg::*;

  logic [NUM_MUTE_CH-1:0] muted, mute_pulse;
  logic [NUM_SRC-1:0]     src_lvl, status_q, set_vec;
  logic [7:0]             mask_q, mode_q;
  logic                   status_clr, irq_q;

  for (genvar ch = 0; ch < NUM_MUTE_CH; ch++) begin : g_chan
    run_detector #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (mute_valid[ch]),
      .data      (mute_data[ch*SAMPLE_W +: SAMPLE_W]),
      .muted     (muted[ch]),
      .mute_pulse(mute_pulse[ch])
    );
  end

  // Channel c lands on status bit 4+c; lower bits follow the fixed order.
  assign src_lvl    = {muted, clk_err, adc_ovfl_pos, adc_ovfl_neg};
  assign status_clr = reg_rd && (reg_addr == ADDR_STATUS);

  src_capture #(.NSRC(NUM_SRC)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (src_lvl),
    .mode_reg(mode_q),
    .clr     (status_clr),
    .status_q(status_q),
    .set_vec (set_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_MODE) mode_q <= reg_wdata;
      irq_q <= |(status_q & ~mask_q);
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_STATUS: reg_rdata = status_q;
      ADDR_MASK:   reg_rdata = mask_q;
      ADDR_MODE:   reg_rdata = mode_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq      = irq_q;
  assign ovfl_out = adc_ovfl_pos | adc_ovfl_neg;

  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |=> !irq);

  p_mute_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_pulse[3] && mode_q[5:4] == 2'b00) |-> set_vec[7]);

endmodule

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  localparam int W  = 8;
  localparam int RL = 6;

  logic           clk = 0, rst_n = 0;
  logic [3:0]     mute_valid = '0;
  logic [4*W-1:0] mute_data = '0;
  logic [1:0]     clk_err = '0;
  logic           adc_ovfl_pos = 0, adc_ovfl_neg = 0;
  logic [1:0]     reg_addr = '0;
  logic           reg_wr = 0, reg_rd = 0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic           irq, ovfl_out;

  int n_tests = 0, n_fail = 0;

  irq_status_ctrl #(.SAMPLE_W(W), .RUN_LEN(RL)) dut (
    .clk(clk), .rst_n(rst_n), .mute_valid(mute_valid), .mute_data(mute_data),
    .clk_err(clk_err), .adc_ovfl_pos(adc_ovfl_pos), .adc_ovfl_neg(adc_ovfl_neg),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .ovfl_out(ovfl_out));

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int         m_cnt [4];
  int         m_kind[4];
  logic [7:0] m_status, m_mask, m_mode, m_prev, m_lv, m_hit;
  logic       m_irq;
  logic [1:0] m_md;
  logic [W-1:0] m_smp;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_cnt[c] = 0; m_kind[c] = 0; end
      m_status = 0; m_mask = 0; m_mode = 0; m_prev = 0; m_irq = 0;
    end else begin
      for (int c = 0; c < 4; c++) m_lv[4+c] = (m_cnt[c] == RL);
      m_lv[3:0] = {clk_err, adc_ovfl_pos, adc_ovfl_neg};
      for (int i = 0; i < 8; i++) begin
        if (i >= 4) m_md = m_mode[5:4];
        else if (i >= 2) m_md = m_mode[3:2];
        else m_md = m_mode[1:0];
        if (m_md == 2'b00)      m_hit[i] = m_lv[i] && !m_prev[i];
        else if (m_md == 2'b01) m_hit[i] = !m_lv[i] && m_prev[i];
        else                    m_hit[i] = m_lv[i];
      end
      m_irq = |(m_status & ~m_mask);
      if (reg_rd && reg_addr == 0) m_status = 0;
      m_status = m_status | m_hit;
      m_prev = m_lv;
      if (reg_wr && reg_addr == 1) m_mask = reg_wdata;
      if (reg_wr && reg_addr == 2) m_mode = reg_wdata;
      for (int c = 0; c < 4; c++) begin
        if (mute_valid[c]) begin
          m_smp = mute_data[c*W +: W];
          if (m_smp == '0 || m_smp == '1) begin
            if (m_cnt[c] > 0 && m_kind[c] == int'(m_smp != '0)) begin
              if (m_cnt[c] < RL) m_cnt[c]++;
            end else begin
              m_cnt[c] = 1; m_kind[c] = int'(m_smp != '0);
            end
          end else m_cnt[c] = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R9 irq vs model", {7'd0, irq}, {7'd0, m_irq});
      chk("R10 ovfl_out live", {7'd0, ovfl_out}, {7'd0, adc_ovfl_pos | adc_ovfl_neg});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    if (a == 0) chk("R5 status read vs model", d, m_status);
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic smp(input int ch, input logic [W-1:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      mute_valid[ch] = 1; mute_data[ch*W +: W] = v;
      @(posedge clk); #1 mute_valid[ch] = 0;
    end
  endtask

  task automatic pulse_src(input int which);
    @(negedge clk);
    case (which)
      0: adc_ovfl_neg = 1;
      1: adc_ovfl_pos = 1;
      2: clk_err[0] = 1;
      default: clk_err[1] = 1;
    endcase
    @(posedge clk); #1;
    adc_ovfl_neg = 0; adc_ovfl_pos = 0; clk_err = '0;
  endtask

  logic [7:0] d;

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    idle(1);
    // R1 reset values
    chk("R1 irq low", {7'd0, irq}, 8'h00);
    rd(0, d); chk("R1 status", d, 8'h00);
    rd(1, d); chk("R1 mask", d, 8'h00);
    rd(2, d); chk("R1 mode", d, 8'h00);
    // R12 register map
    wr(1, 8'hA5); rd(1, d); chk("R12 mask rw", d, 8'hA5);
    wr(2, 8'hFF); rd(2, d); chk("R12 mode rw", d, 8'hFF);
    wr(3, 8'h5A); rd(3, d); chk("R12 addr3 zero", d, 8'h00);
    wr(1, 8'h00); wr(2, 8'h00);
    rd(0, d);
    // R3 bit positions for level sources, R5 clear
    pulse_src(1); idle(1); rd(0, d); chk("R3 pos ovfl bit1", d, 8'h02);
    rd(0, d); chk("R5 cleared", d, 8'h00);
    pulse_src(0); idle(1); rd(0, d); chk("R3 neg ovfl bit0", d, 8'h01);
    pulse_src(3); idle(1); rd(0, d); chk("R3 clkerr port2 bit3", d, 8'h08);
    pulse_src(2); idle(1); rd(0, d); chk("R3 clkerr port1 bit2", d, 8'h04);
    // R2 read-only, R4 sticky
    pulse_src(1); idle(4);
    wr(0, 8'h00); wr(0, 8'hFF); idle(2);
    rd(0, d); chk("R2/R4 status unchanged by writes", d, 8'h02);
    // R6 run length per channel, R3 channel positions
    smp(3, 8'h00, RL-1); idle(2); rd(0, d); chk("R6 one short no event", d, 8'h00);
    smp(3, 8'h00, 1); idle(2); rd(0, d); chk("R6/R3 ch3 bit7", d, 8'h80);
    smp(2, 8'hFF, RL); idle(2); rd(0, d); chk("R6/R3 ch2 ones bit6", d, 8'h40);
    smp(1, 8'h00, RL); idle(2); rd(0, d); chk("R3 ch1 bit5", d, 8'h20);
    smp(0, 8'h00, RL); idle(2); rd(0, d); chk("R3 ch0 bit4", d, 8'h10);
    // R7 restarts
    smp(0, 8'h00, RL-1); idle(2); rd(0, d); chk("R7 muted run no re-event", d, 8'h00);
    smp(0, 8'h01, 1); smp(0, 8'h00, RL-1); idle(2);
    rd(0, d); chk("R7 break restarts run", d, 8'h00);
    smp(0, 8'hFF, RL-1); smp(0, 8'h00, RL-1); idle(2);
    rd(0, d); chk("R7 polarity switch restarts", d, 8'h00);
    smp(0, 8'h00, 1); idle(2); rd(0, d); chk("R7 completed run event", d, 8'h10);
    // R8 mask, R9 irq
    wr(1, 8'h02); pulse_src(1); idle(3);
    chk("R8 masked no irq", {7'd0, irq}, 8'h00);
    wr(1, 8'h00); idle(2);
    chk("R9 unmasked irq high", {7'd0, irq}, 8'h01);
    rd(0, d); chk("R8 status latched while masked", d, 8'h02);
    idle(2); chk("R9 irq low after clear", {7'd0, irq}, 8'h00);
    // R11 trigger modes on overflow group
    wr(2, 8'h01);
    @(negedge clk) adc_ovfl_pos = 1; idle(3);
    rd(0, d); chk("R11 fall mode ignores rise", d, 8'h00);
    @(negedge clk) adc_ovfl_pos = 0; idle(2);
    rd(0, d); chk("R11 fall mode sets on fall", d, 8'h02);
    wr(2, 8'h02);
    @(negedge clk) adc_ovfl_pos = 1; idle(2);
    rd(0, d); chk("R11 level mode", d, 8'h02);
    rd(0, d); chk("R5 level held through read", d, 8'h02);
    @(negedge clk) adc_ovfl_pos = 0; idle(2);
    rd(0, d); chk("R4 sticky after level drop", d, 8'h02);
    rd(0, d); chk("R5 clear after drop", d, 8'h00);
    wr(2, 8'h03);
    @(negedge clk) adc_ovfl_pos = 1; idle(2);
    rd(0, d); chk("R11 mode 11 acts as level", d, 8'h02);
    @(negedge clk) adc_ovfl_pos = 0; idle(1);
    rd(0, d); rd(0, d); chk("R11 mode 11 cleared", d, 8'h00);
    wr(2, 8'h00);
    // R5 event in the same cycle as a read
    idle(1);
    @(negedge clk);
    adc_ovfl_pos = 1; reg_addr = 0; reg_rd = 1;
    #1 chk("R5 read returns pre-clear", reg_rdata, 8'h00);
    @(posedge clk); #1 reg_rd = 0; adc_ovfl_pos = 0;
    rd(0, d); chk("R5 same-cycle event kept", d, 8'h02);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule